// File: doc/BRIEF.md
# Wide Register Collector Bus Interface

This block sits behind a narrow host bus (32 or 64 bits per beat) and gives it atomic access to a bank of internal 128-bit registers and to a window of 64-bit storage entries. A write to a wide register is gathered lane by lane in a staging buffer. Nothing reaches the register until the host writes its top lane, and at that edge all 128 bits change together. A read of the bottom lane takes a snapshot of the whole register into a shadow buffer. Reads of the upper lanes then come from that snapshot, so the host always sees one coherent value even though it fetches it in pieces.

A few small dword registers, such as a queue read pointer and the two descriptor-update pointers, skip the collector entirely. Software can poke them at any time without a lock. One exception applies on page 0: a dword write there would corrupt a collection that is in progress. In that case the block cancels the pending collection and reports the clash on the response. The address space repeats in pages of 0x2000 bytes. Each page has its own wide registers and dword registers, while the 64-bit storage window is shared by all pages.

Top module: `wide_collect_biu`

## Requirements
- R1: After reset every wide register, storage entry and dword register reads as 0, and ack_o, rdata_o, abort_o and clash_o are low.
- R2: Writes to dwords 0, 1 and 2 of a wide register (byte offsets 0, 4, 8) only fill the staging buffer, and the register keeps its old value. A write to dword 3 (offset 12) commits all 128 bits at once, provided a collection is open for that same register.
- R3: A read of dword 0 returns the live dword 0 and copies the whole 128-bit register into the shadow buffer. Reads of dwords 1 to 3 return the shadow contents, which are stale if no dword-0 read came first or if the register changed after the snapshot.
- R4: Dword register k of a page sits at page offset 0x1800 + 16*k (k below NDW). A write to it takes effect at once, and a read returns it directly without touching any shadow.
- R5: A dword register write on page 1 or above, issued while a wide collection is open, sets no flag and leaves the collection intact, so the later dword-3 write still commits.
- R6: A dword register write on page 0 while a wide collection is open still updates the dword register. It also cancels the collection and raises clash_o with its ack, so the following dword-3 write changes nothing.
- R7: A dword-0 write to a different entry than the open collection restarts staging for the new entry and raises abort_o with its ack. A dword-0 write to the same entry restarts it without the flag. The same rule applies to the storage window.
- R8: Storage entry i sits at page offset 0x1000 + 8*i. A write at +0 stages, a write at +4 commits the 64-bit entry, a read at +0 snapshots, and a read at +4 returns the snapshot. The window is shared across all mapped pages.
- R9: Byte address = page*0x2000 + offset, and wide register n sits at offset 16*n. Addresses on pages at or above NPAGE, or outside the three windows, read 0 and writes to them change nothing.
- R10: Every request cycle is answered by ack_o exactly one cycle later, read data arrives with that ack, write acks carry rdata_o = 0, and requests may follow back to back.
- R11: A dword-3 write to a wide register with no open collection for that register is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request valid, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | BUS_W | Write data |
| ack_o | output | 1 | Response, one cycle after the request |
| rdata_o | output | BUS_W | Read data, valid with ack_o |
| abort_o | output | 1 | Collection restarted on another entry (with ack_o) |
| clash_o | output | 1 | Page-0 dword write cancelled a collection (with ack_o) |

## Verification
The bench builds the block with a 32-bit bus, two pages, eight wide registers per page, sixteen storage entries and three dword registers. With the 32-bit bus, every wide register takes four beats and every storage entry takes two. That makes the staging of three lanes reachable, along with stale-shadow reads and restarts in the middle of a collection. Two pages let the same dword write be tried while a collection is open on page 0, where it must clash, and on page 1, where it must not. They also cover reads of an unmapped third page and the shared storage window seen through both pages.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
   localparam int unsigned WCB_PAGE_SHIFT = 13;   // 0x2000-byte pages
   localparam int unsigned WCB_DWORD_W    = 32;

   typedef enum logic [1:0] {
      RGN_NONE  = 2'd0,
      RGN_WIDE  = 2'd1,
      RGN_SRAM  = 2'd2,
      RGN_DWORD = 2'd3
   } wcb_rgn_e;
endpackage

// File: rtl/wcb_decode.sv
module wcb_decode
   import wcb_pkg::*;
#(
   parameter  int ADDR_W = 16,
   parameter  int NPAGE  = 2,
   parameter  int NREG   = 8,
   parameter  int NSRAM  = 16,
   parameter  int NDW    = 3,
   localparam int PW     = $clog2(NPAGE),
   localparam int RW     = $clog2(NREG),
   localparam int SW     = $clog2(NSRAM),
   localparam int DXW    = $clog2(NDW)
) (
   input  logic [ADDR_W-1:0] addr,
   output wcb_rgn_e          rgn,
   output logic [PW-1:0]     page,
   output logic [RW-1:0]     ridx,
   output logic [SW-1:0]     sidx,
   output logic [DXW-1:0]    didx,
   output logic [1:0]        wlane,
   output logic [0:0]        slane
);
   localparam int PFW = ADDR_W - WCB_PAGE_SHIFT;

   logic [12:0]     off;
   logic [PFW-1:0]  pg;
   logic            unused_low;

   assign off        = addr[12:0];
   assign pg         = addr[ADDR_W-1:WCB_PAGE_SHIFT];
   assign unused_low = ^off[1:0];

   always_comb begin
      rgn = RGN_NONE;
      if (int'(pg) < NPAGE) begin
         if (!off[12]) begin
            if ((off[11:4] >> RW) == '0) rgn = RGN_WIDE;
         end else if (!off[11]) begin
            if ((off[10:3] >> SW) == '0) rgn = RGN_SRAM;
         end else if (off[3:0] == '0 && int'(off[10:4]) < NDW) begin
            rgn = RGN_DWORD;
         end
      end
   end

   assign page  = pg[PW-1:0];
   assign ridx  = off[4 +: RW];
   assign sidx  = off[3 +: SW];
   assign didx  = off[4 +: DXW];
   assign wlane = off[3:2];
   assign slane = off[2:2];
endmodule

// File: rtl/wcb_collect.sv
module wcb_collect #(
   parameter  int WIDE  = 128,
   parameter  int BUS_W = 32,
   parameter  int DEPTH = 16,
   localparam int IW    = $clog2(DEPTH),
   localparam int LNW   = $clog2(WIDE / 32)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [IW-1:0]    idx,
   input  logic [LNW-1:0]   dsel,
   input  logic [BUS_W-1:0] wdata,
   input  logic             cancel_i,
   output logic [BUS_W-1:0] rd_word,
   output logic             abort_o,
   output logic             pend_o
);
   localparam int LANES = WIDE / BUS_W;
   localparam int LAST  = LANES - 1;
   localparam int LSH   = $clog2(BUS_W / 32);

   logic [WIDE-1:0] mem_q [DEPTH];
   logic [WIDE-1:0] shadow_q;
   logic [WIDE-1:0] commit_val;
   logic            commit;
   logic            rd_first;

   if (LANES > 1) begin : g_stage
      localparam int LW = $clog2(LANES);
      localparam logic [LW-1:0] LAST_L = LW'(LAST);

      logic [LW-1:0]    lane;
      logic [BUS_W-1:0] stage_q [LANES];
      logic             pend_q;
      logic [IW-1:0]    tag_q;

      assign lane = LW'(dsel >> LSH);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            tag_q  <= '0;
            for (int l = 0; l < LANES; l++) stage_q[l] <= '0;
         end else if (cancel_i) begin
            pend_q <= 1'b0;
         end else if (wr_en) begin
            if (lane != LAST_L) stage_q[lane] <= wdata;
            if (lane == '0) begin
               pend_q <= 1'b1;
               tag_q  <= idx;
            end else if (commit) begin
               pend_q <= 1'b0;
            end
         end
      end

      always_comb begin
         for (int l = 0; l < LANES; l++) begin
            if (l == LAST) commit_val[l*BUS_W +: BUS_W] = wdata;
            else           commit_val[l*BUS_W +: BUS_W] = stage_q[l];
         end
      end

      assign commit   = wr_en && lane == LAST_L && pend_q && tag_q == idx;
      assign abort_o  = wr_en && lane == '0 && pend_q && tag_q != idx;
      assign pend_o   = pend_q;
      assign rd_first = rd_en && lane == '0;
      assign rd_word  = (lane == '0) ? mem_q[idx][BUS_W-1:0]
                                     : shadow_q[lane*BUS_W +: BUS_W];

      // R2 / R7: a dword-0 write opens a collection tagged with its entry
      p_first_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !cancel_i && lane == '0) |=> (pend_q && tag_q == $past(idx)))
         else $error("first-lane write did not open collection");

      // R6: a cancel leaves no collection open
      p_cancel_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
         cancel_i |=> !pend_q)
         else $error("cancel did not close collection");
   end else begin : g_direct
      logic unused_sel;
      assign unused_sel = ^dsel;
      assign commit_val = wdata;
      assign commit     = wr_en;
      assign abort_o    = 1'b0;
      assign pend_o     = 1'b0;
      assign rd_first   = rd_en;
      assign rd_word    = mem_q[idx][BUS_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < DEPTH; d++) mem_q[d] <= '0;
         shadow_q <= '0;
      end else begin
         if (commit)   mem_q[idx] <= commit_val;
         if (rd_first) shadow_q   <= mem_q[idx];
      end
   end

   // R3: the shadow only moves on a first-lane read
   p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_first |=> $stable(shadow_q))
      else $error("shadow changed without snapshot");
endmodule

// File: rtl/wcb_dword_bank.sv
module wcb_dword_bank #(
   parameter  int NPAGE = 2,
   parameter  int NDW   = 3,
   localparam int PW    = $clog2(NPAGE),
   localparam int DXW   = $clog2(NDW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [PW-1:0]  page,
   input  logic [DXW-1:0] didx,
   input  logic [31:0]    wdata,
   output logic [31:0]    rd_word
);
   localparam int NENT = NPAGE * NDW;
   localparam int FW   = $clog2(NENT);

   logic [31:0]   regs_q [NENT];
   logic [FW-1:0] fidx;

   assign fidx    = FW'(int'(page) * NDW + int'(didx));
   assign rd_word = regs_q[fidx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < NENT; e++) regs_q[e] <= '0;
      end else if (wr_en) begin
         regs_q[fidx] <= wdata;
      end
   end
endmodule

// File: rtl/wide_collect_biu.sv
module wide_collect_biu
   import wcb_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int BUS_W       = 32,
   parameter int NPAGE       = 2,
   parameter int NREG        = 8,
   parameter int NSRAM       = 16,
   parameter int NDW         = 3,
   parameter bit GUARD_PAGE0 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic              ack_o,
   output logic [BUS_W-1:0]  rdata_o,
   output logic              abort_o,
   output logic              clash_o
);
   localparam int PW  = $clog2(NPAGE);
   localparam int RW  = $clog2(NREG);
   localparam int SW  = $clog2(NSRAM);
   localparam int DXW = $clog2(NDW);

   // elaboration-time parameter checks
   if (!(BUS_W == 32 || BUS_W == 64)) begin : g_bad_bus
      $error("BUS_W must be 32 or 64");
   end
   if (NPAGE < 2 || (NPAGE & (NPAGE - 1)) != 0) begin : g_bad_page
      $error("NPAGE must be a power of two, at least 2");
   end
   if (NREG < 2 || NREG > 256 || (NREG & (NREG - 1)) != 0) begin : g_bad_reg
      $error("NREG must be a power of two in 2..256");
   end
   if (NSRAM < 2 || NSRAM > 256 || (NSRAM & (NSRAM - 1)) != 0) begin : g_bad_sram
      $error("NSRAM must be a power of two in 2..256");
   end
   if (NDW < 2 || NDW > 128) begin : g_bad_dw
      $error("NDW must lie in 2..128");
   end
   if (ADDR_W < int'(WCB_PAGE_SHIFT) + PW) begin : g_bad_addr
      $error("ADDR_W too narrow for NPAGE");
   end

   wcb_rgn_e         rgn;
   logic [PW-1:0]    page;
   logic [RW-1:0]    ridx;
   logic [SW-1:0]    sidx;
   logic [DXW-1:0]   didx;
   logic [1:0]       wlane;
   logic [0:0]       slane;

   wcb_decode #(
      .ADDR_W(ADDR_W), .NPAGE(NPAGE), .NREG(NREG), .NSRAM(NSRAM), .NDW(NDW)
   ) u_dec (
      .addr(addr_i), .rgn(rgn), .page(page), .ridx(ridx), .sidx(sidx),
      .didx(didx), .wlane(wlane), .slane(slane)
   );

   logic wide_wr, wide_rd, sram_wr, sram_rd, dw_wr;
   assign wide_wr = req_i &&  we_i && rgn == RGN_WIDE;
   assign wide_rd = req_i && !we_i && rgn == RGN_WIDE;
   assign sram_wr = req_i &&  we_i && rgn == RGN_SRAM;
   assign sram_rd = req_i && !we_i && rgn == RGN_SRAM;
   assign dw_wr   = req_i &&  we_i && rgn == RGN_DWORD;

   logic             reg_pend, reg_abort, sram_abort, hazard;
   logic             unused_sram_pend;
   logic [BUS_W-1:0] reg_word, sram_word;
   logic [31:0]      dw_word;

   if (GUARD_PAGE0) begin : g_guard
      assign hazard = dw_wr && page == '0 && reg_pend;
   end else begin : g_noguard
      assign hazard = 1'b0;
   end

   wcb_collect #(.WIDE(128), .BUS_W(BUS_W), .DEPTH(NPAGE * NREG)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wide_wr), .rd_en(wide_rd),
      .idx({page, ridx}), .dsel(wlane), .wdata(wdata_i), .cancel_i(hazard),
      .rd_word(reg_word), .abort_o(reg_abort), .pend_o(reg_pend)
   );

   wcb_collect #(.WIDE(64), .BUS_W(BUS_W), .DEPTH(NSRAM)) u_sram (
      .clk(clk), .rst_n(rst_n), .wr_en(sram_wr), .rd_en(sram_rd),
      .idx(sidx), .dsel(slane), .wdata(wdata_i), .cancel_i(1'b0),
      .rd_word(sram_word), .abort_o(sram_abort), .pend_o(unused_sram_pend)
   );

   wcb_dword_bank #(.NPAGE(NPAGE), .NDW(NDW)) u_dw (
      .clk(clk), .rst_n(rst_n), .wr_en(dw_wr), .page(page), .didx(didx),
      .wdata(wdata_i[31:0]), .rd_word(dw_word)
   );

   logic [BUS_W-1:0] rd_mux;
   always_comb begin
      unique case (rgn)
         RGN_WIDE:  rd_mux = reg_word;
         RGN_SRAM:  rd_mux = sram_word;
         RGN_DWORD: rd_mux = BUS_W'(dw_word);
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_o   <= 1'b0;
         rdata_o <= '0;
         abort_o <= 1'b0;
         clash_o <= 1'b0;
      end else begin
         ack_o   <= req_i;
         rdata_o <= (req_i && !we_i) ? rd_mux : '0;
         abort_o <= reg_abort || sram_abort;
         clash_o <= hazard;
      end
   end

   // R7 / R6: one request per cycle, so a restart and a clash never coincide
   p_abort_clash_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !clash_o)
      else $error("abort and clash together");

   // R6: the clash flag is part of a response
   p_clash_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clash_o |-> ack_o)
      else $error("clash without ack");

   // R10: write acknowledges carry no data
   p_write_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && $past(we_i)) |-> rdata_o == '0)
      else $error("write ack with data");
endmodule

// File: tb/tb_wide_collect_biu.sv
`timescale 1ns/1ps
module tb_wide_collect_biu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic        we_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic        ack_o, abort_o, clash_o;
   logic [31:0] rdata_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [33:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   wide_collect_biu dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
      .abort_o(abort_o), .clash_o(clash_o)
   );

   task automatic check(input bit ok, input string rq, input logic [33:0] act,
                        input logic [33:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
      end
   endtask

   // driver: drives at negedge, pushes the expected response
   task automatic xfer(input bit w, input logic [15:0] a, input logic [31:0] d,
                       input logic [31:0] e, input bit eab, input bit ecl,
                       input string rq);
      req_i   = 1'b1;
      we_i    = w;
      addr_i  = a;
      wdata_i = d;
      exp_q.push_back({eab, ecl, e});
      tag_q.push_back(rq);
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input string rq);
      xfer(1'b1, a, d, 32'h0, 1'b0, 1'b0, rq);
   endtask

   task automatic wrf(input logic [15:0] a, input logic [31:0] d, input bit eab,
                      input bit ecl, input string rq);
      xfer(1'b1, a, d, 32'h0, eab, ecl, rq);
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] e, input string rq);
      xfer(1'b0, a, 32'h0, e, 1'b0, 1'b0, rq);
   endtask

   task automatic idle(input int n);
      req_i = 1'b0;
      we_i  = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor: samples just after each edge and compares in order
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (ack_o) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R10 unexpected ack", {abort_o, clash_o, rdata_o}, 34'h0);
               end else begin
                  logic [33:0] e;
                  string       t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check({abort_o, clash_o, rdata_o} === e, t,
                        {abort_o, clash_o, rdata_o}, e);
               end
            end else if (exp_q.size() != 0) begin
               logic [33:0] e;
               string       t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(1'b0, {"R10 missing ack ", t}, 34'h0, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      check(ack_o === 1'b0 && abort_o === 1'b0 && clash_o === 1'b0 && rdata_o === 32'h0,
            "R1 outputs after reset", {abort_o, clash_o, rdata_o}, 34'h0);
      rd(16'h0000, 32'h0, "R1 wide reg0");
      rd(16'h1800, 32'h0, "R1 dword reg");
      rd(16'h1000, 32'h0, "R1 storage");

      // R2 staging then commit on dword 3
      wr(16'h0000, 32'hA000_0000, "R2");
      wr(16'h0004, 32'hA000_0001, "R2");
      wr(16'h0008, 32'hA000_0002, "R2");
      rd(16'h0000, 32'h0, "R2 not yet committed");
      wr(16'h000C, 32'hA000_0003, "R2");
      rd(16'h0000, 32'hA000_0000, "R2 lane0");
      rd(16'h0004, 32'hA000_0001, "R3 lane1");
      rd(16'h0008, 32'hA000_0002, "R3 lane2");
      rd(16'h000C, 32'hA000_0003, "R3 lane3");

      // R3 stale shadow
      wr(16'h0010, 32'hB000_0000, "R2");
      wr(16'h0014, 32'hB000_0001, "R2");
      wr(16'h0018, 32'hB000_0002, "R2");
      wr(16'h001C, 32'hB000_0003, "R2");
      rd(16'h0014, 32'hA000_0001, "R3 stale without lane0 read");
      rd(16'h0010, 32'hB000_0000, "R3 snapshot");
      rd(16'h0018, 32'hB000_0002, "R3 from shadow");
      wr(16'h0010, 32'hC000_0000, "R2");
      wr(16'h0014, 32'hC000_0001, "R2");
      wr(16'h0018, 32'hC000_0002, "R2");
      wr(16'h001C, 32'hC000_0003, "R2");
      rd(16'h001C, 32'hB000_0003, "R3 shadow not live");
      rd(16'h0010, 32'hC000_0000, "R3 fresh snapshot");

      // R4 dword registers, both pages
      wr(16'h1800, 32'hD000_0000, "R4");
      wr(16'h1810, 32'hD000_0001, "R4");
      wr(16'h1820, 32'hD000_0002, "R4");
      wr(16'h3800, 32'hE000_0000, "R4");
      rd(16'h1810, 32'hD000_0001, "R4 readback");
      rd(16'h1820, 32'hD000_0002, "R4 readback");
      rd(16'h3800, 32'hE000_0000, "R4 page1");
      rd(16'h1800, 32'hD000_0000, "R4 page0 separate");

      // R5 page-1 dword write inside a page-1 collection
      wr(16'h2020, 32'hF000_0000, "R5");
      wr(16'h2024, 32'hF000_0001, "R5");
      wrf(16'h3810, 32'hE000_0001, 1'b0, 1'b0, "R5 no clash on page1");
      wr(16'h2028, 32'hF000_0002, "R5");
      wr(16'h202C, 32'hF000_0003, "R5");
      rd(16'h2020, 32'hF000_0000, "R5 committed");
      rd(16'h202C, 32'hF000_0003, "R5 committed");
      rd(16'h0020, 32'h0, "R9 page0 copy untouched");
      rd(16'h3810, 32'hE000_0001, "R5 dword took effect");

      // R6 page-0 dword write inside a collection
      wr(16'h0030, 32'h6000_0000, "R6");
      wr(16'h0034, 32'h6000_0001, "R6");
      wrf(16'h1800, 32'hD000_0003, 1'b0, 1'b1, "R6 clash flag");
      wr(16'h0038, 32'h6000_0002, "R6");
      wr(16'h003C, 32'h6000_0003, "R6");
      rd(16'h0030, 32'h0, "R6 collection cancelled");
      rd(16'h003C, 32'h0, "R11 no commit");
      rd(16'h1800, 32'hD000_0003, "R6 dword written");
      wrf(16'h1810, 32'hD000_0004, 1'b0, 1'b0, "R6 no clash when idle");

      // R7 restart on a different register
      wr(16'h0040, 32'h4000_0000, "R7");
      wrf(16'h0050, 32'h5000_0000, 1'b1, 1'b0, "R7 abort flag");
      wr(16'h0054, 32'h5000_0001, "R7");
      wr(16'h0058, 32'h5000_0002, "R7");
      wr(16'h004C, 32'h4000_0003, "R11");
      wr(16'h005C, 32'h5000_0003, "R7");
      rd(16'h0040, 32'h0, "R11 old target untouched");
      rd(16'h0050, 32'h5000_0000, "R7 new target");
      rd(16'h0054, 32'h5000_0001, "R7 new target");
      rd(16'h005C, 32'h5000_0003, "R7 new target");
      wr(16'h0060, 32'h7000_0000, "R7");
      wrf(16'h0060, 32'h7000_0009, 1'b0, 1'b0, "R7 same entry no abort");
      wr(16'h0064, 32'h7000_0001, "R7");
      wr(16'h0068, 32'h7000_0002, "R7");
      wr(16'h006C, 32'h7000_0003, "R7");
      rd(16'h0060, 32'h7000_0009, "R7 restarted value");
      rd(16'h006C, 32'h7000_0003, "R7");

      // R8 storage window
      wr(16'h1008, 32'h5A00_0000, "R8");
      rd(16'h1008, 32'h0, "R8 not yet committed");
      wr(16'h100C, 32'h5A00_0001, "R8");
      rd(16'h3008, 32'h5A00_0000, "R8 shared via page1");
      rd(16'h100C, 32'h5A00_0001, "R8 upper from shadow");
      rd(16'h1004, 32'h5A00_0001, "R8 stale shadow");
      wr(16'h1010, 32'h5B00_0000, "R8");
      wrf(16'h1018, 32'h5C00_0000, 1'b1, 1'b0, "R7 storage abort");
      wr(16'h101C, 32'h5C00_0001, "R8");
      rd(16'h1018, 32'h5C00_0000, "R8 commit");
      rd(16'h101C, 32'h5C00_0001, "R8 commit");

      // R9 decode edges
      wr(16'h4000, 32'h9999_9999, "R9");
      rd(16'h4000, 32'h0, "R9 page2 unmapped");
      rd(16'h0080, 32'h0, "R9 beyond table");
      wr(16'h1830, 32'h8888_8888, "R9");
      rd(16'h1830, 32'h0, "R9 dword idx beyond NDW");
      wr(16'h0070, 32'h7700_0000, "R9");
      wr(16'h0074, 32'h7700_0001, "R9");
      wr(16'h0078, 32'h7700_0002, "R9");
      wr(16'h007C, 32'h7700_0003, "R9");
      rd(16'h0070, 32'h7700_0000, "R9 last table entry");
      rd(16'h007C, 32'h7700_0003, "R9 last table entry");

      // R10 idle: no ack without a request
      idle(3);
      check(ack_o === 1'b0, "R10 no ack when idle", {33'h0, ack_o}, 34'h0);
      check(exp_q.size() == 0, "R10 all requests answered",
            34'(exp_q.size()), 34'h0);
      summary();
      $finish;
   end
endmodule